// File: doc/BRIEF.md
# One-Time-Programmable Word Memory with Mode Decoder

This block is a synthesizable model of a write-once, 16-bit-wide memory array. It is not a physical part. Each cycle it takes a chip select, an output gate, a program strobe and two qualifier flags. The first flag says that programming voltage is present. The second says that address bit 9 carries an overvoltage. From these it decodes one of seven operating modes: read, output off, standby, program, program verify, program inhibit and identifier read. It then either updates the array or presents a word. A separate output-valid qualifier stands in for a tri-state driver.

A blank cell reads as all ones. Programming can only clear bits, so a write stores the old word ANDed with the new data. A synchronous erase input returns the whole array to its blank state, and so does reset. In identifier mode the block returns fixed codes instead of array contents, so that programming equipment can recognise the device.

The full-size device holds 128K words (`ADDR_W` = 17). The default depth is kept small so that the model elaborates quickly. All strobes are active low.

Top module: `prom_mode_array`

## Requirements
- R1: After reset the outputs are off (`dout_en` = 0, `dout` = 0), and every location then reads 16'hFFFF.
- R2: A program cycle stores the previous word ANDed with `din`, so a bit once cleared never returns to one.
- R3: With `ce_n` high the outputs are off on the next cycle, whatever the value of `oe_n`.
- R4: With `ce_n` low and `oe_n` high (and not in program mode) the outputs are off.
- R5: With `ce_n`, `oe_n` low and both `vpp_hi` and `a9_hv` low, the stored word at `addr` is driven with `dout_en` = 1.
- R6: With `vpp_hi` = 1, `ce_n` = 0 and `pgm_n` = 0, all 16 bits of `din` are written in parallel and the outputs are off, regardless of `oe_n`.
- R7: With `vpp_hi` = 1, `ce_n` = 0, `oe_n` = 0 and `pgm_n` = 1, the stored word is driven (program verify).
- R8: With `vpp_hi` = 1 and `ce_n` = 1, no write takes place even if `pgm_n` = 0, and the outputs are off.
- R9: With `a9_hv` = 1, `vpp_hi` = 0 and `ce_n`, `oe_n` low, `addr[0]` = 0 returns 16'h0001 and `addr[0]` = 1 returns 16'h0098. Both codes have odd parity with bit 7 as the parity bit. All other address bits are ignored and the upper byte is zero.
- R10: When `vpp_hi` and `a9_hv` are both set, the programming modes take precedence over identifier read.
- R11: Outputs are registered: they reflect the inputs sampled at a rising edge and hold until the next edge. A write made at one edge is visible to a read sampled at the following edge.
- R12: Asserting `erase` at an edge restores every location to 16'hFFFF and blocks any program write decoded at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears outputs and marks the array blank |
| erase | input | 1 | Synchronous erase of the whole array to all ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming voltage present |
| a9_hv | input | 1 | Overvoltage on address bit 9 (identifier request) |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Program data |
| dout | output | 16 | Registered output word |
| dout_en | output | 1 | Output valid; stands in for the tri-state enable |

## Verification
Every visible result, whether a driven word, a disabled output or an identifier code, is due at the first rising edge after the inputs that select it. A program write is due in the array at that same edge, so a verify or read issued in the next cycle shows it. The bench changes inputs on the falling edge and samples 1 ns after the following rising edge, so each check lands one register stage after its stimulus. One check also samples just before an edge, to confirm that the previous word is still held. Effects that leave the outputs unchanged, such as inhibited writes and erase taking priority over a program write, are observed afterwards by reading the affected addresses back.

// File: rtl/prom_pkg.sv
package prom_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_INHIBIT = 3'd1,
    M_DISABLE = 3'd2,
    M_READ    = 3'd3,
    M_PROGRAM = 3'd4,
    M_VERIFY  = 3'd5,
    M_IDENT   = 3'd6
  } prom_mode_e;

  localparam logic [7:0] ID_MAKER  = 8'h01;
  localparam logic [7:0] ID_DEVICE = 8'h98;
endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
  import prom_pkg::*;
(
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       pgm_n,
  input  logic       vpp_hi,
  input  logic       a9_hv,
  output prom_mode_e mode
);
  // Priority: chip select, then programming voltage, then output gate,
  // then identifier request.
  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? M_INHIBIT : M_STANDBY;
    end else if (vpp_hi && !pgm_n) begin
      mode = M_PROGRAM;
    end else if (oe_n) begin
      mode = M_DISABLE;
    end else if (vpp_hi) begin
      mode = M_VERIFY;
    end else if (a9_hv) begin
      mode = M_IDENT;
    end else begin
      mode = M_READ;
    end
  end
endmodule

// File: rtl/prom_cell_array.sv
module prom_cell_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DEPTH-1:0]  used_q;
  logic [DEPTH-1:0]  used_d;
  logic              wr_go;

  assign wr_go   = wr_en & ~erase;
  assign rd_word = used_q[addr] ? cells[addr] : {DATA_W{1'b1}};

  always_comb begin
    used_d = used_q;
    if (erase) begin
      used_d = '0;
    end else if (wr_go) begin
      used_d[addr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else begin
      used_q <= used_d;
    end
  end

  // Data cells carry no reset; the used vector masks stale contents.
  always_ff @(posedge clk) begin
    if (wr_go) begin
      cells[addr] <= rd_word & wr_data;
    end
  end
endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage
  import prom_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  prom_mode_e        mode,
  input  logic              sel_dev,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int PAD_W = DATA_W - 8;

  logic [DATA_W-1:0] id_word;
  logic [DATA_W-1:0] dout_d;
  logic              en_d;

  generate
    if (PAD_W > 0) begin : g_pad
      assign id_word = {{PAD_W{1'b0}}, (sel_dev ? ID_DEVICE : ID_MAKER)};
    end else begin : g_nopad
      assign id_word = DATA_W'(sel_dev ? ID_DEVICE : ID_MAKER);
    end
  endgenerate

  always_comb begin
    dout_d = '0;
    en_d   = 1'b0;
    unique case (mode)
      M_READ, M_VERIFY: begin
        dout_d = word;
        en_d   = 1'b1;
      end
      M_IDENT: begin
        dout_d = id_word;
        en_d   = 1'b1;
      end
      default: begin
        dout_d = '0;
        en_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= dout_d;
      dout_en <= en_d;
    end
  end
endmodule

// File: rtl/prom_mode_array.sv
module prom_mode_array
  import prom_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  prom_mode_e        mode;
  logic [DATA_W-1:0] word;
  logic              wr_en;

  assign wr_en = (mode == M_PROGRAM);

  prom_mode_decode u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_hi (vpp_hi),
    .a9_hv  (a9_hv),
    .mode   (mode)
  );

  prom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase   (erase),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (din),
    .rd_word (word)
  );

  prom_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .sel_dev (addr[0]),
    .word    (word),
    .dout    (dout),
    .dout_en (dout_en)
  );
endmodule

// File: rtl/prom_mode_array_chk.sv
module prom_mode_array_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              erase,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       din,
  input logic [15:0]       dout,
  input logic              dout_en
);
  p_standby_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_en);

  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |=> !dout_en);

  p_prog_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && vpp_hi && !pgm_n) |=> !dout_en);

  p_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !(vpp_hi && !pgm_n)) |=> dout_en);

  p_maker_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && a9_hv && !vpp_hi && !addr[0]) |=> (dout == 16'h0001));

  p_device_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && a9_hv && !vpp_hi && addr[0]) |=> (dout == 16'h0098));

  p_off_is_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 16'h0000));
endmodule

bind prom_mode_array prom_mode_array_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/prom_mode_array_test.sv
`timescale 1ns/1ps
module prom_mode_array_test;
  localparam int AW = 8;

  logic          clk;
  logic          rst_n;
  logic          erase;
  logic          ce_n;
  logic          oe_n;
  logic          pgm_n;
  logic          vpp_hi;
  logic          a9_hv;
  logic [AW-1:0] addr;
  logic [15:0]   din;
  logic [15:0]   dout;
  logic          dout_en;

  int checks;
  int fails;

  prom_mode_array #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .erase(erase), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual en/data=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, then sample just after the next rising edge.
  task automatic cycle(input logic c, input logic o, input logic p, input logic v,
                       input logic h, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic e);
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = h; addr = a; din = d; erase = e;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'h0000, 1'b0);
  endtask

  task automatic t_reset;
    #1;
    check("R1 reset outputs off", {dout_en, dout}, 17'h0_0000);
    @(posedge clk); #1;
    check("R1 outputs off during reset", {dout_en, dout}, 17'h0_0000);
    @(negedge clk);
    rst_n = 1'b1;
    rd(8'h05);
    check("R1 blank read", {dout_en, dout}, {1'b1, 16'hFFFF});
    rd(8'hC3);
    check("R5 read other blank word", {dout_en, dout}, {1'b1, 16'hFFFF});
  endtask

  task automatic t_program;
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h05, 16'hA5C3, 1'b0);
    check("R6 program outputs off with oe low", {dout_en, dout}, 17'h0_0000);
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 16'h0000, 1'b0);
    check("R7/R11 verify next cycle", {dout_en, dout}, {1'b1, 16'hA5C3});
    cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h05, 16'h0F0F, 1'b0);
    check("R6 program with oe high", {dout_en, dout}, 17'h0_0000);
    rd(8'h05);
    check("R2 AND of old and new", {dout_en, dout}, {1'b1, 16'h0503});
    rd(8'h06);
    check("R5 neighbour untouched", {dout_en, dout}, {1'b1, 16'hFFFF});
  endtask

  task automatic t_hold;
    @(negedge clk);
    addr = 8'h06;
    #8;
    check("R11 output held before edge", {dout_en, dout}, {1'b1, 16'hFFFF});
    @(posedge clk); #1;
    addr = 8'h05;
    @(posedge clk); #1;
    check("R11 new word after edge", {dout_en, dout}, {1'b1, 16'h0503});
  endtask

  task automatic t_standby_disable;
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 16'h0000, 1'b0);
    check("R3 standby oe low", {dout_en, dout}, 17'h0_0000);
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05, 16'h0000, 1'b0);
    check("R3 standby oe high", {dout_en, dout}, 17'h0_0000);
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05, 16'h0000, 1'b0);
    check("R4 output disable", {dout_en, dout}, 17'h0_0000);
  endtask

  task automatic t_inhibit;
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h07, 16'h0000, 1'b0);
    check("R8 inhibit outputs off", {dout_en, dout}, 17'h0_0000);
    rd(8'h07);
    check("R8 inhibited word still blank", {dout_en, dout}, {1'b1, 16'hFFFF});
  endtask

  task automatic t_ident;
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFE, 16'h0000, 1'b0);
    check("R9 maker code, other bits set", {dout_en, dout}, {1'b1, 16'h0001});
    cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 16'h0000, 1'b0);
    check("R9 device code", {dout_en, dout}, {1'b1, 16'h0098});
    check("R9 device code odd parity", {16'h0, ^dout[7:0]}, 17'h0_0001);
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01, 16'h0000, 1'b0);
    check("R4 identifier gated by oe", {dout_en, dout}, 17'h0_0000);
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h05, 16'h0000, 1'b0);
    check("R10 verify wins over identifier", {dout_en, dout}, {1'b1, 16'h0503});
  endtask

  task automatic t_erase;
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h09, 16'h0000, 1'b1);
    rd(8'h09);
    check("R12 write blocked by erase", {dout_en, dout}, {1'b1, 16'hFFFF});
    rd(8'h05);
    check("R12 erase restores blank", {dout_en, dout}, {1'b1, 16'hFFFF});
    cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h05, 16'h1234, 1'b0);
    rd(8'h05);
    check("R2 program after erase", {dout_en, dout}, {1'b1, 16'h1234});
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; erase = 1'b0; ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1;
    vpp_hi = 1'b0; a9_hv = 1'b0; addr = '0; din = '0;
    t_reset();
    t_program();
    t_hold();
    t_standby_disable();
    t_inhibit();
    t_ident();
    t_erase();
    finish_run();
  end
endmodule